// File: doc/BRIEF.md
# FIFO Threshold Request Controller

This block watches the fill level of a byte FIFO that an SPI channel shares between its transmit and receive directions. The FIFO storage and the shift engine live elsewhere; here they appear only as single-cycle byte strobes. Host writes and SPI receptions add a byte. SPI transmissions and host reads remove one. From the level, the block decides when the host must refill the transmit side or drain the receive side.

Two 6-bit thresholds are held in one configuration word. The free-space threshold sits in bits [5:0] and the occupancy threshold in bits [13:8]. A direction is armed only while the channel and that direction's FIFO enable are both set.

When a condition is met, the block raises a request. In DMA mode the request drives a DMA request line. In interrupt mode it sets a sticky status bit instead. The first host access of the transfer drops the request. The request then stays low until exactly threshold+1 host accesses have been made. A reception that arrives while the FIFO is full sets a sticky overflow bit.

Top module: `fthr_req_ctrl`

## Requirements
- R1: After a synchronous reset, `level`, `status`, `irq`, `dma_tx_req` and `dma_rx_req` are all zero, and both thresholds are zero.
- R2: `level` rises by one on a push strobe (`host_wr` or `spi_rx`) and falls by one on a pop strobe (`host_rd` or `spi_tx`). A push and a pop in the same cycle leave it unchanged. It never goes below 0 or above DEPTH: a pop on an empty FIFO or a push on a full FIFO is dropped, and only the other strobe of the cycle takes effect.
- R3: The transmit request is registered. It is high in the cycle after an edge when, with the transmit direction armed, DEPTH minus the updated level exceeds the free-space threshold. It is not high while a burst is in progress.
- R4: The receive request follows the same rules, using the condition that the updated level exceeds the occupancy threshold.
- R5: A host access in the direction of a raised request (`host_wr` for transmit, `host_rd` for receive) drops that request at the next edge. The request is not raised again until threshold+1 accesses in total have been made in that direction, even if the level condition holds in between.
- R6: With `dma_mode` = 1, requests appear only on `dma_tx_req` and `dma_rx_req`, and status bits 0 and 1 are never set. With `dma_mode` = 0, both DMA lines stay low. In that mode, a rising transmit request sets `status[0]` and a rising receive request sets `status[1]`.
- R7: `spi_rx` while `level` equals DEPTH, with receive armed and no pop in the same cycle, sets the sticky overflow bit `status[2]`.
- R8: Status bits are sticky. Writing 1 to a bit of `sts_clr` clears that bit, and a set in the same cycle wins over the clear.
- R9: `irq` is registered and equals the OR, over all bits, of `status` ANDed with `irq_en`, one cycle earlier.
- R10: Clearing `chan_en` or a direction's FIFO enable drops that direction's request at the next edge and discards any partly completed burst.
- R11: A `cfg_we` pulse loads the free-space threshold from `cfg_wdata[5:0]` and the occupancy threshold from `cfg_wdata[13:8]`. The new values take effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable |
| tx_fifo_en | input | 1 | Arms the transmit threshold logic |
| rx_fifo_en | input | 1 | Arms the receive threshold logic |
| dma_mode | input | 1 | 1: requests go to DMA lines; 0: requests go to status bits |
| cfg_we | input | 1 | Threshold register write strobe |
| cfg_wdata | input | 16 | Threshold register write data |
| host_wr | input | 1 | Host wrote one byte (push) |
| host_rd | input | 1 | Host read one byte (pop) |
| spi_rx | input | 1 | SPI completed a byte reception (push) |
| spi_tx | input | 1 | SPI consumed a byte for transmission (pop) |
| sts_clr | input | 3 | Write-1-to-clear strobes for status |
| irq_en | input | 3 | Interrupt enables per status bit |
| level | output | 7 | Current FIFO occupancy in bytes |
| status | output | 3 | Bit 0 transmit request, bit 1 receive request, bit 2 overflow |
| irq | output | 1 | Interrupt line |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The assertions assume that every strobe lasts one cycle and stands for one byte. They also assume that the FIFO enables, `dma_mode` and the thresholds may change in any cycle, including in the middle of a burst. The random stimulus relies on this: it draws all strobes independently. It also flips the enables and the mode at random moments, so that bursts get abandoned and conditions change while a request is high. Directed sequences come first. They take the level to both ends, hold a burst open while the level condition stays true, and push into a full FIFO.

// File: rtl/fthr_pkg.sv
package fthr_pkg;
  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;
  localparam int NDIR   = 2;

  localparam int STS_TXE = 0;
  localparam int STS_RXF = 1;
  localparam int STS_OVF = 2;
  localparam int STS_W   = 3;
endpackage

// File: rtl/fthr_level.sv
module fthr_level #(
  parameter int DEPTH = 64,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  output logic [LVL_W-1:0] level_q,
  output logic [LVL_W-1:0] level_nx
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  always_comb begin
    level_nx = level_q;
    if (push && !pop) begin
      if (level_q != FULL) level_nx = level_q + 1'b1;
    end else if (pop && !push) begin
      if (level_q != '0) level_nx = level_q - 1'b1;
    end else if (push && pop) begin
      if (level_q == '0)        level_nx = level_q + 1'b1;
      else if (level_q == FULL) level_nx = level_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= level_nx;
  end
endmodule

// File: rtl/fthr_gate.sv
module fthr_gate #(
  parameter int TH_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic            acc,
  input  logic            cond,
  input  logic            dma_mode,
  input  logic [TH_W-1:0] th,
  output logic            req_o,
  output logic            dma_o,
  output logic            rise_o
);
  logic            busy_q, busy_n;
  logic [TH_W-1:0] rem_q, rem_n;
  logic            req_q, req_n;
  logic            start;

  always_comb begin
    start  = active && !busy_q && req_q && acc;
    busy_n = 1'b0;
    rem_n  = '0;
    req_n  = 1'b0;
    if (active) begin
      if (busy_q) begin
        busy_n = !(acc && rem_q == TH_W'(1));
        rem_n  = acc ? rem_q - 1'b1 : rem_q;
      end else if (start) begin
        busy_n = (th != '0);
        rem_n  = th;
      end
      req_n = cond && !busy_n && !start;
    end
  end

  assign rise_o = req_n && !req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      req_q  <= 1'b0;
      dma_o  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      rem_q  <= rem_n;
      req_q  <= req_n;
      dma_o  <= req_n && dma_mode;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/fthr_status.sv
module fthr_status #(
  parameter int NB = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] set,
  input  logic [NB-1:0] clr,
  input  logic [NB-1:0] en,
  output logic [NB-1:0] sts,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= '0;
      irq <= 1'b0;
    end else begin
      sts <= (sts & ~clr) | set;
      irq <= |(sts & en);
    end
  end
endmodule

// File: rtl/fthr_req_ctrl.sv
module fthr_req_ctrl
  import fthr_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int TH_W    = 6,
  parameter int CFG_W   = 16,
  parameter int AEL_LSB = 0,
  parameter int AFL_LSB = 8,
  parameter int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_en,
  input  logic             tx_fifo_en,
  input  logic             rx_fifo_en,
  input  logic             dma_mode,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic             spi_rx,
  input  logic             spi_tx,
  input  logic [STS_W-1:0] sts_clr,
  input  logic [STS_W-1:0] irq_en,
  output logic [LVL_W-1:0] level,
  output logic [STS_W-1:0] status,
  output logic             irq,
  output logic             dma_tx_req,
  output logic             dma_rx_req
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic [TH_W-1:0]  ael_q, afl_q;
  logic [LVL_W-1:0] level_nx;
  logic             push, pop;
  logic [NDIR-1:0]  active, acc, cond, req, dma, rise;
  logic [TH_W-1:0]  th [NDIR];
  logic [STS_W-1:0] sts_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      ael_q <= '0;
      afl_q <= '0;
    end else if (cfg_we) begin
      ael_q <= cfg_wdata[AEL_LSB +: TH_W];
      afl_q <= cfg_wdata[AFL_LSB +: TH_W];
    end
  end

  assign push = host_wr | spi_rx;
  assign pop  = host_rd | spi_tx;

  fthr_level #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_level (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .level_q(level), .level_nx(level_nx)
  );

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    if (d == DIR_TX) begin : g_tx
      assign active[d] = chan_en & tx_fifo_en;
      assign acc[d]    = host_wr;
      assign th[d]     = ael_q;
      assign cond[d]   = (FULL - level_nx) > LVL_W'(ael_q);
    end else begin : g_rx
      assign active[d] = chan_en & rx_fifo_en;
      assign acc[d]    = host_rd;
      assign th[d]     = afl_q;
      assign cond[d]   = level_nx > LVL_W'(afl_q);
    end
    fthr_gate #(.TH_W(TH_W)) u_gate (
      .clk(clk), .rst(rst), .active(active[d]), .acc(acc[d]),
      .cond(cond[d]), .dma_mode(dma_mode), .th(th[d]),
      .req_o(req[d]), .dma_o(dma[d]), .rise_o(rise[d])
    );
  end

  assign sts_set[STS_TXE] = rise[DIR_TX] & ~dma_mode;
  assign sts_set[STS_RXF] = rise[DIR_RX] & ~dma_mode;
  assign sts_set[STS_OVF] = active[DIR_RX] & spi_rx & (level == FULL) & ~pop;

  fthr_status #(.NB(STS_W)) u_status (
    .clk(clk), .rst(rst), .set(sts_set), .clr(sts_clr), .en(irq_en),
    .sts(status), .irq(irq)
  );

  assign dma_tx_req = dma[DIR_TX];
  assign dma_rx_req = dma[DIR_RX];
endmodule

// File: rtl/fthr_req_ctrl_chk.sv
module fthr_req_ctrl_chk #(
  parameter int DEPTH = 64,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             chan_en,
  input logic             rx_fifo_en,
  input logic             dma_mode,
  input logic             host_wr,
  input logic             host_rd,
  input logic             spi_rx,
  input logic             spi_tx,
  input logic [2:0]       irq_en,
  input logic [LVL_W-1:0] level,
  input logic [2:0]       status,
  input logic             irq,
  input logic             dma_tx_req,
  input logic             dma_rx_req
);
  assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH));

  assert_empty_pop_R2: assert property (@(posedge clk) disable iff (rst)
    (level == '0 && (host_rd || spi_tx) && !host_wr && !spi_rx) |=> level == '0);

  assert_tx_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (dma_tx_req && host_wr) |=> !dma_tx_req);

  assert_rx_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (dma_rx_req && host_rd) |=> !dma_rx_req);

  assert_dma_mode_R6: assert property (@(posedge clk) disable iff (rst)
    (dma_tx_req || dma_rx_req) |-> $past(dma_mode));

  assert_int_mode_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(status[0]) || $rose(status[1])) |-> !$past(dma_mode));

  assert_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (chan_en && rx_fifo_en && spi_rx && level == LVL_W'(DEPTH) && !host_rd && !spi_tx)
    |=> status[2]);

  assert_irq_R9: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(status & irq_en)));

  assert_chan_off_R10: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> (!dma_tx_req && !dma_rx_req));
endmodule

bind fthr_req_ctrl fthr_req_ctrl_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .chan_en(chan_en), .rx_fifo_en(rx_fifo_en),
  .dma_mode(dma_mode), .host_wr(host_wr), .host_rd(host_rd),
  .spi_rx(spi_rx), .spi_tx(spi_tx), .irq_en(irq_en), .level(level),
  .status(status), .irq(irq), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
);

// File: tb/fthr_req_ctrl_tb.sv
module fthr_req_ctrl_tb;
  localparam int D = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic chan_en = 0, tx_fifo_en = 0, rx_fifo_en = 0, dma_mode = 0, cfg_we = 0;
  logic [15:0] cfg_wdata = '0;
  logic host_wr = 0, host_rd = 0, spi_rx = 0, spi_tx = 0;
  logic [2:0] sts_clr = '0, irq_en = '0;
  logic [6:0] level;
  logic [2:0] status;
  logic irq, dma_tx_req, dma_rx_req;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int m_level, m_ael, m_afl;
  bit m_busy[2], m_req[2], m_dma[2];
  int m_rem[2];
  bit [2:0] m_sts;
  bit m_irq;

  always #2 clk = ~clk;

  fthr_req_ctrl u_dut (
    .clk(clk), .rst(rst), .chan_en(chan_en), .tx_fifo_en(tx_fifo_en),
    .rx_fifo_en(rx_fifo_en), .dma_mode(dma_mode), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .host_wr(host_wr), .host_rd(host_rd),
    .spi_rx(spi_rx), .spi_tx(spi_tx), .sts_clr(sts_clr), .irq_en(irq_en),
    .level(level), .status(status), .irq(irq),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int next_level(int l, bit psh, bit pp);
    if (psh && !pp) return (l < D) ? l + 1 : l;
    if (pp && !psh) return (l > 0) ? l - 1 : l;
    if (psh && pp) begin
      if (l == 0) return 1;
      if (l == D) return D - 1;
    end
    return l;
  endfunction

  task automatic model_step();
    int nl;
    bit psh, pp, act, acc, cnd, start, nb, nq;
    int th, nr;
    bit [2:0] set;
    psh = host_wr | spi_rx;
    pp  = host_rd | spi_tx;
    nl  = next_level(m_level, psh, pp);
    set = '0;
    for (int d = 0; d < 2; d++) begin
      act = chan_en && (d == 0 ? tx_fifo_en : rx_fifo_en);
      acc = (d == 0) ? host_wr : host_rd;
      th  = (d == 0) ? m_ael : m_afl;
      cnd = (d == 0) ? ((D - nl) > m_ael) : (nl > m_afl);
      nb = 0; nr = 0; nq = 0; start = 0;
      if (act) begin
        start = !m_busy[d] && m_req[d] && acc;
        if (m_busy[d]) begin
          nb = !(acc && m_rem[d] == 1);
          nr = acc ? m_rem[d] - 1 : m_rem[d];
        end else if (start) begin
          nb = (th != 0);
          nr = th;
        end
        nq = cnd && !nb && !start;
      end
      if (nq && !m_req[d] && !dma_mode) set[d] = 1'b1;
      m_busy[d] = nb; m_rem[d] = nr; m_req[d] = nq;
      m_dma[d]  = nq && dma_mode;
    end
    if (chan_en && rx_fifo_en && spi_rx && m_level == D && !pp) set[2] = 1'b1;
    m_irq   = |(m_sts & irq_en);
    m_sts   = (m_sts & ~sts_clr) | set;
    m_level = nl;
    if (cfg_we) begin
      m_ael = int'(cfg_wdata[5:0]);
      m_afl = int'(cfg_wdata[13:8]);
    end
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    #1;
    chk("R2 level", int'(level), m_level);
    chk("R3 dma_tx_req", int'(dma_tx_req), int'(m_dma[0]));
    chk("R4 dma_rx_req", int'(dma_rx_req), int'(m_dma[1]));
    chk("R8 status", int'(status), int'(m_sts));
    chk("R9 irq", int'(irq), int'(m_irq));
    @(negedge clk);
    {host_wr, host_rd, spi_rx, spi_tx, cfg_we} = '0;
    sts_clr = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_level = 0; m_ael = 0; m_afl = 0; m_sts = '0; m_irq = 0;
    for (int d = 0; d < 2; d++) begin
      m_busy[d] = 0; m_req[d] = 0; m_dma[d] = 0; m_rem[d] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    chk("R1 level", int'(level), 0);
    chk("R1 status", int'(status), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 dma", int'({dma_tx_req, dma_rx_req}), 0);
    @(negedge clk);

    // R11: load free-space threshold 3, occupancy threshold 7
    cfg_we = 1; cfg_wdata = 16'h0703; cycle();
    chan_en = 1; dma_mode = 1;
    for (int i = 0; i < 61; i++) begin host_wr = 1; cycle(); end
    tx_fifo_en = 1; cycle();
    chk("R11 free 3 not above threshold", int'(dma_tx_req), 0);
    spi_tx = 1; cycle();
    chk("R3 free 4 raises tx request", int'(dma_tx_req), 1);
    host_wr = 1; cycle();
    chk("R5 first write drops request", int'(dma_tx_req), 0);
    for (int i = 0; i < 3; i++) begin spi_tx = 1; cycle(); end
    chk("R5 held low mid burst", int'(dma_tx_req), 0);
    chk("R2 level mid burst", int'(level), 58);
    for (int i = 0; i < 2; i++) begin host_wr = 1; cycle(); end
    chk("R5 still low before last write", int'(dma_tx_req), 0);
    host_wr = 1; cycle();
    spi_tx = 1; cycle();
    chk("R5 re-raised after full burst", int'(dma_tx_req), 1);
    chan_en = 0; cycle();
    chk("R10 channel off drops request", int'(dma_tx_req), 0);

    // R6: interrupt mode
    chan_en = 1; dma_mode = 0; irq_en = 3'b001; cycle();
    chk("R6 status tx set", int'(status[0]), 1);
    chk("R6 no dma in int mode", int'(dma_tx_req), 0);
    cycle();
    chk("R9 irq follows status", int'(irq), 1);
    sts_clr = 3'b001; cycle();
    chk("R8 w1c clears", int'(status[0]), 0);

    // R7: overflow on full FIFO
    tx_fifo_en = 0; rx_fifo_en = 1;
    while (level < 7'(D)) begin spi_rx = 1; cycle(); end
    spi_rx = 1; cycle();
    chk("R7 overflow set", int'(status[2]), 1);
    chk("R2 level saturates at full", int'(level), D);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom;
      host_wr = (r[2:0] == 0);
      host_rd = (r[5:3] == 0);
      spi_rx  = (r[8:6] == 0);
      spi_tx  = (r[11:9] == 0);
      if (r[17:12] == 0) chan_en    = ~chan_en;
      if (r[23:18] == 1) tx_fifo_en = ~tx_fifo_en;
      if (r[29:24] == 2) dma_mode   = ~dma_mode;
      if (r[31:30] == 0 && r[17:12] == 5) rx_fifo_en = ~rx_fifo_en;
      r = $urandom;
      if (r[6:0] == 0) begin cfg_we = 1; cfg_wdata = 16'($urandom); end
      if (r[9:7] == 0) sts_clr = 3'($urandom);
      if (r[15:10] == 0) irq_en = 3'($urandom);
      if (r[23:16] == 0 && !chan_en) chan_en = 1;
      cycle();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule